// File: doc/BRIEF.md
# GPIO Configurable Interrupt Event Detector

This block watches 32 general-purpose input lines and raises one interrupt when a configured event is seen on any of them. Each line is first brought into the clock domain through a two-flop synchroniser. A third flop holds the previous synchronised sample, and edges are found by comparing the two. By default a line reports any change of its input. When its extended mode is switched on, the line instead reports a rising edge, a falling edge, a low level or a high level, as selected by two per-line settings: a kind (edge or level) and a polarity (falling/low or rising/high).

Detected events set per-line bits in a status word. Software reads that word through a simple register bus, and the read clears the word. A line that is held in a level mode keeps setting its bit again while the level lasts. Each status bit is ANDed with a per-line mask bit, and the results are ORed into a single interrupt output. All configuration uses pairs of write-one-to-set and write-one-to-clear addresses, and each setting can be read back at its own status address.

Top module: `pin_event_detector`

Register word addresses on `bus_addr_i`: 0 mode on, 1 mode off, 2 mode status, 3 select edge, 4 select level, 5 kind status (1 = level), 6 select falling/low, 7 select rising/high, 8 polarity status (1 = rising/high), 9 mask on, 10 mask off, 11 mask status, 12 event status (clear on read). A read is a cycle with `bus_req_i` high and `bus_we_i` low. Data is returned combinationally in the same cycle.

## Requirements
- R1: After reset, every status address reads 0 and `irq_o` is low. This means any-change mode, edge kind, falling/low polarity and all lines masked.
- R2: A change on `pin_i` can first set a status bit on the third rising clock edge after the change (two synchroniser flops, then the status register).
- R3: With the extended mode off for a line (mode status bit 0), both a rising and a falling change of that line set its status bit.
- R4: With the extended mode on and the kind set to edge, only a rising change (polarity 1) or only a falling change (polarity 0) sets the status bit.
- R5: With the extended mode on and the kind set to level, the status bit is set on every cycle in which the synchronised line equals the selected level (1 for high, 0 for low). A read therefore does not leave the bit clear while the level holds.
- R6: A read of address 12 returns the pending bits and clears all of them. An event detected on the same clock edge as the read stays set.
- R7: `irq_o` is high exactly when some bit is set in both the event status and the mask status.
- R8: In each set/clear pair, writing 1 to a bit sets or clears that setting for the line, writing 0 leaves it unchanged, and the result reads back at the pair's status address. Write-only addresses read as 0, and writes to read-only addresses have no effect.
- R9: Every line uses only its own mode, kind, polarity and mask bits. Events on one line never set another line's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | Asynchronous input lines |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data, one bit per line |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that a bus access lasts one cycle and that the address and write strobe are stable in that cycle. They also assume that the pin inputs may change at any time, because only the synchronised copy is used. The stimulus drives bus signals and pins only on the falling clock edge, issues single-cycle accesses, and keeps pin toggles sparse so that edges, level holds and reads that land on the same edge as an event all occur. A bench model is advanced on each rising edge from the stimulus alone and supplies the expected read data and interrupt level.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE_ON   = 4'd0,
    A_MODE_OFF  = 4'd1,
    A_MODE_STAT = 4'd2,
    A_SEL_EDGE  = 4'd3,
    A_SEL_LEVEL = 4'd4,
    A_KIND_STAT = 4'd5,
    A_SEL_LOW   = 4'd6,
    A_SEL_HIGH  = 4'd7,
    A_POL_STAT  = 4'd8,
    A_MASK_ON   = 4'd9,
    A_MASK_OFF  = 4'd10,
    A_MASK_STAT = 4'd11,
    A_EVT_STAT  = 4'd12
  } reg_addr_e;
endpackage

// File: rtl/pid_sync.sv
module pid_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pid_setclr.sv
module pid_setclr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q | set_i) & ~clr_i;
  end

  assign q_o = q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> (q == $past(q)));
endmodule

// File: rtl/pid_detect.sv
module pid_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] kind_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] evt_o
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic rise, fall, lvl, edg;
    assign rise = cur_i[i] & ~prev_i[i];
    assign fall = ~cur_i[i] & prev_i[i];
    assign lvl  = pol_i[i] ? cur_i[i] : ~cur_i[i];
    assign edg  = pol_i[i] ? rise : fall;
    assign evt_o[i] = !mode_i[i] ? (rise | fall) : (kind_i[i] ? lvl : edg);
  end
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import pid_pkg::*;
#(
  parameter int unsigned LINES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  pin_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [LINES-1:0]  bus_wdata_i,
  output logic [LINES-1:0]  bus_rdata_o,
  output logic              irq_o
);
  localparam logic [LINES-1:0] ZERO = '0;

  logic             wr, rd_stat;
  logic [LINES-1:0] cur_w, prev_w, evt_w;
  logic [LINES-1:0] mode_q, kind_q, pol_q, mask_q, status_q;

  assign wr      = bus_req_i & bus_we_i;
  assign rd_stat = bus_req_i & ~bus_we_i & (bus_addr_i == A_EVT_STAT);

  function automatic logic [LINES-1:0] wsel(input reg_addr_e a);
    return (wr && bus_addr_i == a) ? bus_wdata_i : ZERO;
  endfunction

  pid_sync #(.W(LINES)) u_sync (
    .clk_i, .rst_ni, .pin_i, .cur_o(cur_w), .prev_o(prev_w)
  );

  pid_setclr #(.W(LINES)) u_mode (
    .clk_i, .rst_ni, .set_i(wsel(A_MODE_ON)), .clr_i(wsel(A_MODE_OFF)), .q_o(mode_q)
  );
  pid_setclr #(.W(LINES)) u_kind (
    .clk_i, .rst_ni, .set_i(wsel(A_SEL_LEVEL)), .clr_i(wsel(A_SEL_EDGE)), .q_o(kind_q)
  );
  pid_setclr #(.W(LINES)) u_pol (
    .clk_i, .rst_ni, .set_i(wsel(A_SEL_HIGH)), .clr_i(wsel(A_SEL_LOW)), .q_o(pol_q)
  );
  pid_setclr #(.W(LINES)) u_mask (
    .clk_i, .rst_ni, .set_i(wsel(A_MASK_ON)), .clr_i(wsel(A_MASK_OFF)), .q_o(mask_q)
  );

  pid_detect #(.W(LINES)) u_det (
    .cur_i(cur_w), .prev_i(prev_w), .mode_i(mode_q), .kind_i(kind_q),
    .pol_i(pol_q), .evt_o(evt_w)
  );

  // events on the read edge survive the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (rd_stat ? ZERO : status_q) | evt_w;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i) begin
      case (bus_addr_i)
        A_MODE_STAT: bus_rdata_o = mode_q;
        A_KIND_STAT: bus_rdata_o = kind_q;
        A_POL_STAT:  bus_rdata_o = pol_q;
        A_MASK_STAT: bus_rdata_o = mask_q;
        A_EVT_STAT:  bus_rdata_o = status_q;
        default:     bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(status_q & mask_q);

  p_clear_keeps_evt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> (status_q == $past(evt_w)));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == ZERO) |-> !irq_o);

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    p_level_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[i] && kind_q[i] && (pol_q[i] == cur_w[i])) |=> status_q[i]);
    p_quiet_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_stat && !evt_w[i]) |=> (status_q[i] == $past(status_q[i])));
  end
endmodule

// File: tb/pin_event_detector_tb_top.sv
module pin_event_detector_tb_top;
  localparam int N = 32;

  logic          clk = 0, rst_n = 0;
  logic [N-1:0]  pin = '0;
  logic          req = 0, we = 0;
  logic [3:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq;

  int n_chk = 0, n_fail = 0;

  pin_event_detector #(.LINES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  always #2 clk = ~clk;

  // bench model, advanced from stimulus only
  logic [N-1:0] m_s1, m_s2, m_p, m_mode, m_kind, m_pol, m_mask, m_stat;

  function automatic logic [N-1:0] f_evt(input logic [N-1:0] c, p, md, kd, pl);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (!md[i])     r[i] = c[i] ^ p[i];
      else if (kd[i]) r[i] = pl[i] ? c[i] : ~c[i];
      else            r[i] = pl[i] ? (c[i] & ~p[i]) : (~c[i] & p[i]);
    end
    return r;
  endfunction

  function automatic logic [N-1:0] f_read(input logic [3:0] a);
    case (a)
      4'd2:  return m_mode;
      4'd5:  return m_kind;
      4'd8:  return m_pol;
      4'd11: return m_mask;
      4'd12: return m_stat;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_s1, m_s2, m_p, m_mode, m_kind, m_pol, m_mask, m_stat} = '0;
    end else begin
      logic [N-1:0] e;
      e = f_evt(m_s2, m_p, m_mode, m_kind, m_pol);
      m_stat = ((req && !we && addr == 4'd12) ? '0 : m_stat) | e;
      if (req && we) begin
        case (addr)
          4'd0:  m_mode = m_mode | wdata;
          4'd1:  m_mode = m_mode & ~wdata;
          4'd3:  m_kind = m_kind & ~wdata;
          4'd4:  m_kind = m_kind | wdata;
          4'd6:  m_pol  = m_pol & ~wdata;
          4'd7:  m_pol  = m_pol | wdata;
          4'd9:  m_mask = m_mask | wdata;
          4'd10: m_mask = m_mask & ~wdata;
          default: ;
        endcase
      end
      m_p = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic chk(input string r, input logic [N-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // one bus cycle: sample irq, drive, sample read data
  task automatic cyc(input string r, input logic rq, w, input logic [3:0] a,
                     input logic [N-1:0] d);
    @(negedge clk);
    chk({r, " irq"}, {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    req = rq; we = w; addr = a; wdata = d;
    #1;
    if (rq && !w) chk(r, rdata, f_read(a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc("R7", 0, 0, 4'd0, '0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 13; a++) begin
      @(negedge clk); req = 1; we = 0; addr = 4'(a); #1;
      chk("R1", rdata, '0);
    end
    @(negedge clk); req = 0; chk("R1 irq", {31'd0, irq}, '0);

    // R2 latency: line 0 rising, masked in
    cyc("R8", 1, 1, 4'd0, 32'h1);
    cyc("R8", 1, 1, 4'd7, 32'h1);
    cyc("R8", 1, 1, 4'd9, 32'h1);
    cyc("R8", 1, 0, 4'd2, '0);
    cyc("R8", 1, 0, 4'd8, '0);
    @(negedge clk); req = 0; pin[0] = 1;
    @(negedge clk); chk("R2 one edge", {31'd0, irq}, '0);
    @(negedge clk); chk("R2 two edges", {31'd0, irq}, '0);
    @(negedge clk); chk("R2 three edges", {31'd0, irq}, 32'd1);
    cyc("R6 read", 1, 0, 4'd12, '0);
    cyc("R6 cleared", 1, 0, 4'd12, '0);
    // R4 falling on rising-only line gives nothing
    @(negedge clk); req = 0; pin[0] = 0;
    idle(5);
    cyc("R4", 1, 0, 4'd12, '0);
    chk("R4 no fall", rdata & 32'h1, '0);

    // R3 any-change on line 3, event on same edge as read (R6)
    cyc("R6", 1, 0, 4'd12, '0);
    @(negedge clk); req = 0; pin[3] = 1;
    @(negedge clk);
    @(negedge clk); req = 1; we = 0; addr = 4'd12; #1;
    chk("R6 before", rdata & 32'h8, '0);
    cyc("R3 rise kept R6", 1, 0, 4'd12, '0);
    chk("R3 rise", rdata & 32'h8, 32'h8);
    @(negedge clk); req = 0; pin[3] = 0;
    idle(4);
    cyc("R3 fall", 1, 0, 4'd12, '0);
    chk("R3 fall bit", rdata & 32'h8, 32'h8);

    // R5 high level on line 5
    cyc("R8", 1, 1, 4'd0, 32'h20);
    cyc("R8", 1, 1, 4'd4, 32'h20);
    cyc("R8", 1, 1, 4'd7, 32'h20);
    cyc("R8", 1, 1, 4'd2, 32'hffff_ffff);  // read-only write ignored
    cyc("R8", 1, 0, 4'd2, '0);
    cyc("R8", 1, 0, 4'd5, '0);
    @(negedge clk); req = 0; pin[5] = 1;
    idle(4);
    cyc("R5 first", 1, 0, 4'd12, '0);
    cyc("R5 again", 1, 0, 4'd12, '0);
    chk("R5 held", rdata & 32'h20, 32'h20);
    @(negedge clk); req = 0; pin[5] = 0;
    idle(4);
    cyc("R5 drop", 1, 0, 4'd12, '0);
    cyc("R5 gone", 1, 0, 4'd12, '0);
    chk("R5 gone bit", rdata & 32'h20, '0);

    // random mix, R4 R5 R6 R7 R8 R9 against model
    for (int it = 0; it < 6000; it++) begin
      int unsigned c = $urandom_range(0, 9);
      pin = pin ^ ($urandom & $urandom & $urandom & $urandom);
      if (c < 3)      cyc("R8 cfg", 1, 1, 4'($urandom_range(0, 12)), $urandom);
      else if (c < 5) cyc("R6 stat R9", 1, 0, 4'd12, '0);
      else if (c < 6) cyc("R8 read", 1, 0, 4'($urandom_range(0, 15)), '0);
      else            cyc("R7", 0, 0, 4'd0, '0);
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule